// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an inbound PCI DMA address into a system memory address. Four programmable windows each hold an enable/base register, a size mask register and a translated-base register. A window that matches maps its region either directly onto a contiguous system range or through a single-level page table. In the page-table case the block fetches one 64-bit entry over a request/acknowledge read port. The result is a hit flag, the translated base address and an offset mask. The caller combines the low address bits under the mask with the returned base.

Two special paths handle 64-bit (dual-address-cycle) PCI addresses. A control bit opens a large direct window that maps one terabyte-aligned range onto system address zero. The last window can be moved from the 32-bit space to a page-table path for the upper half of the 44-bit space. A second control bit punches a hole at 0x80000 to 0xFFFFF in the 32-bit space, where nothing matches. The translator accepts one request at a time. It raises `xlBusy` while it works and pulses `xlDone` with the result.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset the control register and every window register read as 0, except the last window's base register, which reads 2. `xlDone`, `xlBusy` and `memReq` are low.
- R2: Register selects 0 to 3 are the window base registers. A write to windows 0 to 2 keeps the bits under 0xFFF0_0003 (bit 0 enable, bit 1 page-table mode, bits 31:20 base). A write to window 3 keeps 0x80_FFF0_0001 and forces bit 1 to one. Bit 39 of window 3 moves that window to the 64-bit path.
- R3: Selects 4 to 7 are the window size masks and keep bits 31:20. Selects 8 to 11 are the translated bases and keep 0x7_FFFF_FC00. Select 12 is the control register, and a write changes only the bits under 0x1C_FF0F_C7FF.
- R4: A direct-mode hit returns hit=1. The address is the translated base AND NOT(mask OR 0xFFFFF), and the offset mask is (mask OR 0xFFFFF).
- R5: A window matches when it is enabled and the address AND NOT(mask OR 0xFFFFF) equals its base bits 31:20. When several windows match, the lowest index wins, and a disabled window never matches.
- R6: A miss returns hit=0 with address 0 and mask 0.
- R7: In page-table mode the entry address is (tba AND NOT(mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). An entry with bit 0 set returns ((entry AND 0x3FFFFE)<<12) with offset mask 0x1FFF.
- R8: A fetched entry with bit 0 clear gives a miss.
- R9: With control bit 5 set, a 32-bit address from 0x80000 to 0xFFFFF misses without any window lookup or fetch.
- R10: For 32-bit addresses, window 3 takes part only while its bit 39 is clear. When it is skipped and nothing else hits, no fetch is issued.
- R11: With control bit 6 set, an address in [0x100_0000_0000, 0x200_0000_0000) hits with address 0 and mask 0x7_FFFF_FFFF.
- R12: An address in 0x800_0000_0000 to 0xFFF_FFFF_FFFF, with window 3 bits 39 and 0 both set, fetches the entry at (tba3 AND 0x7_FFC0_0000) OR ((addr AND 0xFFFF_E000)>>10). The result then follows R7 and R8.
- R13: `xlDone` is a one-cycle pulse. It comes two cycles after an accepted request when no fetch is needed, and one cycle after the `memAck` cycle when a fetch is needed. `memReq` holds until acknowledged. Requests made while `xlBusy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgSel | input | 4 | Register select (read and write) |
| cfgWdata | input | 64 | Configuration write data |
| cfgRdData | output | 64 | Contents of the selected register |
| xlReq | input | 1 | Translation request |
| xlAddr | input | 44 | PCI address to translate |
| xlBusy | output | 1 | A translation is in progress |
| memReq | output | 1 | Page-table entry read request |
| memAddr | output | 35 | Page-table entry address |
| memAck | input | 1 | Read data valid, ends the request |
| memData | input | 64 | Page-table entry |
| xlDone | output | 1 | Result valid pulse |
| xlHit | output | 1 | Translation succeeded |
| xlOutAddr | output | 35 | Translated system base address |
| xlOutMask | output | 35 | Offset mask for the translated address |

## Verification
If a window register holds the wrong value, or the priority order is wrong, the next request that reaches that window shows it. The symptom is a wrong base or mask, or a wrong entry address on `memAddr` one cycle after the request is captured. A stuck or misdirected control state shows up as a missing, doubled or late `xlDone` pulse, or as a `memReq` that drops before its acknowledge. The scoreboard pairs every pulse with the result and the latency it expects. It also flags any pulse that nothing asked for, so a request accepted while busy is caught within a few cycles.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  parameter int PCI_AW  = 44;
  parameter int SYS_AW  = 35;
  parameter int DATA_W  = 64;
  parameter int SEL_W   = 4;
  parameter int NUM_WIN = 4;
  parameter int BASE_W  = 40;
  parameter int MASK_W  = 32;
  parameter int CTL_W   = 40;

  localparam int LAST_WIN = NUM_WIN - 1;
  localparam int SEL_MASK0 = NUM_WIN;
  localparam int SEL_TBA0  = 2 * NUM_WIN;
  localparam int SEL_CTL   = 3 * NUM_WIN;

  localparam logic [BASE_W-1:0] BASE_KEEP     = 40'h00_FFF0_0003;
  localparam logic [BASE_W-1:0] BASE_LAST_KEEP = 40'h80_FFF0_0001;
  localparam logic [MASK_W-1:0] MASK_KEEP     = 32'hFFF0_0000;
  localparam logic [SYS_AW-1:0] TBA_KEEP      = 35'h7_FFFF_FC00;
  localparam logic [CTL_W-1:0]  CTL_KEEP      = 40'h1C_FF0F_C7FF;

  localparam logic [MASK_W-1:0] PAGE_EXT  = 32'h000F_FFFF;
  localparam logic [MASK_W-1:0] SG_SELECT = 32'h000F_E000;
  localparam logic [MASK_W-1:0] DAC_SEL   = 32'hFFFF_E000;
  localparam logic [SYS_AW-1:0] DAC_TBA   = 35'h7_FFC0_0000;
  localparam logic [SYS_AW-1:0] BIG_MASK  = 35'h7_FFFF_FFFF;
  localparam logic [SYS_AW-1:0] PTE_MASK  = 35'h0_0000_1FFF;

  localparam int CTL_HOLE_BIT = 5;
  localparam int CTL_BIG_BIT  = 6;
  localparam int DAC_BIT      = 39;

  typedef enum logic [1:0] {
    KIND_MISS,
    KIND_DIRECT,
    KIND_FETCH
  } kind_t;

  typedef struct packed {
    logic capture;
    logic latchEval;
    logic latchPte;
  } strobe_t;
endpackage

// File: rtl/pdx_regs.sv
module pdx_regs
  import pdx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [DATA_W-1:0]   cfgWdata,
  output logic [DATA_W-1:0]   cfgRdData,
  output logic [BASE_W-1:0]   winBase [NUM_WIN],
  output logic [MASK_W-1:0]   winMask [NUM_WIN],
  output logic [SYS_AW-1:0]   winTba  [NUM_WIN],
  output logic [CTL_W-1:0]    ctlReg
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic selBase, selMask, selTba;
    assign selBase = cfgWr && (cfgSel == SEL_W'(w));
    assign selMask = cfgWr && (cfgSel == SEL_W'(SEL_MASK0 + w));
    assign selTba  = cfgWr && (cfgSel == SEL_W'(SEL_TBA0 + w));

    if (w == LAST_WIN) begin : g_last
      always_ff @(posedge clk) begin
        if (!rstN)        winBase[w] <= BASE_W'(2);
        else if (selBase) winBase[w] <= (cfgWdata[BASE_W-1:0] & BASE_LAST_KEEP) | BASE_W'(2);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)        winBase[w] <= '0;
        else if (selBase) winBase[w] <= cfgWdata[BASE_W-1:0] & BASE_KEEP;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        winMask[w] <= '0;
        winTba[w]  <= '0;
      end else begin
        if (selMask) winMask[w] <= cfgWdata[MASK_W-1:0] & MASK_KEEP;
        if (selTba)  winTba[w]  <= cfgWdata[SYS_AW-1:0] & TBA_KEEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctlReg <= '0;
    else if (cfgWr && cfgSel == SEL_W'(SEL_CTL))
      ctlReg <= (ctlReg & ~CTL_KEEP) | (cfgWdata[CTL_W-1:0] & CTL_KEEP);
  end

  always_comb begin
    cfgRdData = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (cfgSel == SEL_W'(w))             cfgRdData = DATA_W'(winBase[w]);
      if (cfgSel == SEL_W'(SEL_MASK0 + w)) cfgRdData = DATA_W'(winMask[w]);
      if (cfgSel == SEL_W'(SEL_TBA0 + w))  cfgRdData = DATA_W'(winTba[w]);
    end
    if (cfgSel == SEL_W'(SEL_CTL)) cfgRdData = DATA_W'(ctlReg);
  end

  // R2: the last window always stays in page-table mode
  a_r2_last_win_sg: assert property (@(posedge clk) disable iff (!rstN)
    winBase[LAST_WIN][1]);
  // R3: read-only control bits never change from reset
  a_r3_ctl_fixed_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReg & ~CTL_KEEP) == '0);

endmodule

// File: rtl/pdx_datapath.sv
module pdx_datapath
  import pdx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [PCI_AW-1:0]   xlAddr,
  input  logic [BASE_W-1:0]   winBase [NUM_WIN],
  input  logic [MASK_W-1:0]   winMask [NUM_WIN],
  input  logic [SYS_AW-1:0]   winTba  [NUM_WIN],
  input  logic [CTL_W-1:0]    ctlReg,
  input  logic [DATA_W-1:0]   memData,
  output kind_t               kind,
  output logic [SYS_AW-1:0]   pteAddrQ,
  output logic                hitQ,
  output logic [SYS_AW-1:0]   outAddrQ,
  output logic [SYS_AW-1:0]   outMaskQ
);

  logic [PCI_AW-1:0] addrQ;
  logic [MASK_W-1:0] lowAddr;
  logic              isSingle, inHole, inBig, inDac;
  logic [NUM_WIN-1:0] winHit;
  logic [SYS_AW-1:0] winDirAddr [NUM_WIN];
  logic [SYS_AW-1:0] winDirMask [NUM_WIN];
  logic [SYS_AW-1:0] winPteAddr [NUM_WIN];
  logic [SYS_AW-1:0] dacPteAddr;
  logic [SYS_AW-1:0] pteAddrC, dirAddrC, dirMaskC;

  assign lowAddr  = addrQ[MASK_W-1:0];
  assign isSingle = addrQ[PCI_AW-1:MASK_W] == '0;
  assign inHole   = ctlReg[CTL_HOLE_BIT] && lowAddr >= 32'h0008_0000 && lowAddr <= 32'h000F_FFFF;
  assign inBig    = ctlReg[CTL_BIG_BIT] && addrQ[PCI_AW-1:40] == 4'h1;
  assign inDac    = addrQ[PCI_AW-1] && winBase[LAST_WIN][DAC_BIT] && winBase[LAST_WIN][0];
  assign dacPteAddr = (winTba[LAST_WIN] & DAC_TBA) | SYS_AW'((lowAddr & DAC_SEL) >> 10);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    logic [MASK_W-1:0] extMask;
    logic              allowed;
    assign extMask = winMask[w] | PAGE_EXT;
    if (w == LAST_WIN) begin : g_dac_gate
      assign allowed = !winBase[w][DAC_BIT];
    end else begin : g_open
      assign allowed = 1'b1;
    end
    assign winHit[w] = allowed && winBase[w][0] &&
                       ((lowAddr & ~extMask) == {winBase[w][31:20], 20'h0});
    assign winDirAddr[w] = winTba[w] & ~SYS_AW'(extMask);
    assign winDirMask[w] = SYS_AW'(extMask);
    assign winPteAddr[w] = (winTba[w] & ~SYS_AW'(winMask[w] >> 10)) |
                           SYS_AW'((lowAddr & (winMask[w] | SG_SELECT)) >> 10);
  end

  always_comb begin
    kind     = KIND_MISS;
    pteAddrC = '0;
    dirAddrC = '0;
    dirMaskC = '0;
    if (isSingle) begin
      if (!inHole) begin
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
          if (winHit[w]) begin
            kind     = winBase[w][1] ? KIND_FETCH : KIND_DIRECT;
            pteAddrC = winPteAddr[w];
            dirAddrC = winDirAddr[w];
            dirMaskC = winDirMask[w];
          end
        end
      end
    end else if (inBig) begin
      kind     = KIND_DIRECT;
      dirMaskC = BIG_MASK;
    end else if (inDac) begin
      kind     = KIND_FETCH;
      pteAddrC = dacPteAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      pteAddrQ <= '0;
      hitQ     <= 1'b0;
      outAddrQ <= '0;
      outMaskQ <= '0;
    end else begin
      if (strobe.capture) addrQ <= xlAddr;
      if (strobe.latchEval) begin
        pteAddrQ <= pteAddrC;
        hitQ     <= kind == KIND_DIRECT;
        outAddrQ <= (kind == KIND_DIRECT) ? dirAddrC : '0;
        outMaskQ <= (kind == KIND_DIRECT) ? dirMaskC : '0;
      end
      if (strobe.latchPte) begin
        hitQ     <= memData[0];
        outAddrQ <= memData[0] ? (SYS_AW'(memData[21:1]) << 13) : '0;
        outMaskQ <= memData[0] ? PTE_MASK : '0;
      end
    end
  end

  logic unusedPteBits;
  assign unusedPteBits = ^memData[DATA_W-1:22];

  // R13: capture and result latching never coincide
  a_r13_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.capture, strobe.latchEval, strobe.latchPte}) <= 1);

endmodule

// File: rtl/pdx_ctrl.sv
module pdx_ctrl
  import pdx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    xlReq,
  input  kind_t   kind,
  input  logic    memAck,
  output strobe_t strobe,
  output logic    memReq,
  output logic    busy,
  output logic    doneQ
);

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_FETCH} state_t;
  state_t state;

  always_comb begin
    strobe           = '0;
    strobe.capture   = (state == ST_IDLE) && xlReq;
    strobe.latchEval = state == ST_EVAL;
    strobe.latchPte  = (state == ST_FETCH) && memAck;
  end

  assign memReq = state == ST_FETCH;
  assign busy   = state != ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE:  if (xlReq) state <= ST_EVAL;
        ST_EVAL: begin
          if (kind == KIND_FETCH) state <= ST_FETCH;
          else begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        ST_FETCH: if (memAck) begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: result pulse lasts one cycle
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R13: read request holds until acknowledged
  a_r13_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  // R13: a pulse is preceded by evaluation or an acknowledged fetch
  a_r13_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(state == ST_EVAL || (memReq && memAck)));

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
  import pdx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [DATA_W-1:0]   cfgWdata,
  output logic [DATA_W-1:0]   cfgRdData,
  input  logic                xlReq,
  input  logic [PCI_AW-1:0]   xlAddr,
  output logic                xlBusy,
  output logic                memReq,
  output logic [SYS_AW-1:0]   memAddr,
  input  logic                memAck,
  input  logic [DATA_W-1:0]   memData,
  output logic                xlDone,
  output logic                xlHit,
  output logic [SYS_AW-1:0]   xlOutAddr,
  output logic [SYS_AW-1:0]   xlOutMask
);

  logic [BASE_W-1:0] winBase [NUM_WIN];
  logic [MASK_W-1:0] winMask [NUM_WIN];
  logic [SYS_AW-1:0] winTba  [NUM_WIN];
  logic [CTL_W-1:0]  ctlReg;
  strobe_t           strobe;
  kind_t             kind;

  pdx_regs i_regs (
    .clk, .rstN, .cfgWr, .cfgSel, .cfgWdata, .cfgRdData,
    .winBase, .winMask, .winTba, .ctlReg
  );

  pdx_ctrl i_ctrl (
    .clk, .rstN, .xlReq, .kind, .memAck,
    .strobe, .memReq, .busy(xlBusy), .doneQ(xlDone)
  );

  pdx_datapath i_dp (
    .clk, .rstN, .strobe, .xlAddr,
    .winBase, .winMask, .winTba, .ctlReg, .memData,
    .kind, .pteAddrQ(memAddr),
    .hitQ(xlHit), .outAddrQ(xlOutAddr), .outMaskQ(xlOutMask)
  );

  // R6: a miss reports no address and no mask
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    xlDone && !xlHit |-> xlOutAddr == '0 && xlOutMask == '0);
  // R7: a page-table hit always has a page-sized offset mask
  a_r7_pte_mask: assert property (@(posedge clk) disable iff (!rstN)
    xlDone && xlHit && $past(memReq && memAck) |-> xlOutMask == PTE_MASK);
  // R13: no result while a fetch is still open
  a_r13_no_done_in_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !xlDone);

endmodule

// File: tb/test_pci_dma_xlate.sv
module test_pci_dma_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [63:0] cfgWdata = '0;
  logic [63:0] cfgRdData;
  logic        xlReq = 1'b0;
  logic [43:0] xlAddr = '0;
  logic        xlBusy, memReq, memAck = 1'b0;
  logic [34:0] memAddr;
  logic [63:0] memData = '0;
  logic        xlDone, xlHit;
  logic [34:0] xlOutAddr, xlOutMask;

  pci_dma_xlate i_pci_dma_xlate (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic        hit;
    logic [34:0] addr;
    logic [34:0] mask;
    bit          fetch;
    int          reqCyc;
    string       tag;
  } item_t;

  item_t sb[$];
  int errors = 0, checks = 0, cyc = 0, ackCyc = 0, fetchCount = 0, doneCount = 0, waitCnt = 0;
  logic [34:0] pteAddrExp = '0;
  logic [63:0] pteWord = '0;
  string curTag = "";

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges two cycles after a request appears
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      waitCnt++;
      if (waitCnt == 2) begin
        check(memAddr == pteAddrExp, curTag, "entry address", 64'(memAddr), 64'(pteAddrExp));
        memData = pteWord;
        memAck = 1'b1;
        ackCyc = cyc;
        fetchCount++;
        waitCnt = 0;
      end
    end
  end

  // monitor: pairs each done pulse with the oldest expectation
  always @(negedge clk) begin
    if (rstN && xlDone) begin
      item_t it;
      doneCount++;
      if (sb.size() == 0) check(1'b0, "R13", "unexpected done", 64'(cyc), 64'(0));
      else begin
        it = sb.pop_front();
        check(xlHit == it.hit, it.tag, "hit", 64'(xlHit), 64'(it.hit));
        check(xlOutAddr == it.addr, it.tag, "address", 64'(xlOutAddr), 64'(it.addr));
        check(xlOutMask == it.mask, it.tag, "mask", 64'(xlOutMask), 64'(it.mask));
        if (it.fetch) check(cyc == ackCyc + 1, "R13", "fetch latency", 64'(cyc), 64'(ackCyc + 1));
        else check(cyc == it.reqCyc + 2, "R13", "direct latency", 64'(cyc), 64'(it.reqCyc + 2));
      end
    end
  end

  task automatic cfgWrite(logic [3:0] sel, logic [63:0] data);
    @(negedge clk);
    cfgWr = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic cfgCheck(logic [3:0] sel, logic [63:0] exp, string req);
    @(negedge clk);
    cfgSel = sel;
    #1;
    check(cfgRdData == exp, req, "register read", cfgRdData, exp);
  endtask

  task automatic push(logic hit, logic [34:0] addr, logic [34:0] mask, bit fetch, string tag);
    item_t it;
    it.hit = hit; it.addr = addr; it.mask = mask; it.fetch = fetch;
    it.reqCyc = cyc; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 100 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, curTag, "result missing", 64'(sb.size()), 64'(0));
    sb.delete();
    @(negedge clk);
  endtask

  task automatic xlate(logic [43:0] a, logic hit, logic [34:0] oAddr, logic [34:0] oMask,
                       bit fetch, logic [34:0] pAddr, logic [63:0] pWord, string tag);
    @(negedge clk);
    curTag = tag; pteAddrExp = pAddr; pteWord = pWord;
    push(hit, oAddr, oMask, fetch, tag);
    xlReq = 1'b1; xlAddr = a;
    @(negedge clk);
    xlReq = 1'b0;
    waitDrain();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R13 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int fc, dc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(!xlDone && !xlBusy && !memReq, "R1", "idle outputs", {xlDone, xlBusy, memReq}, 0);
    cfgCheck(4'd3, 64'h2, "R1");
    cfgCheck(4'd0, 64'h0, "R1");
    cfgCheck(4'd12, 64'h0, "R1");
    // R2 / R3 write masks
    cfgWrite(4'd0, '1);  cfgCheck(4'd0, 64'hFFF0_0003, "R2");
    cfgWrite(4'd3, '1);  cfgCheck(4'd3, 64'h80_FFF0_0003, "R2");
    cfgWrite(4'd3, 64'h0); cfgCheck(4'd3, 64'h2, "R2");
    cfgWrite(4'd4, '1);  cfgCheck(4'd4, 64'hFFF0_0000, "R3");
    cfgWrite(4'd8, '1);  cfgCheck(4'd8, 64'h7_FFFF_FC00, "R3");
    // window setup
    cfgWrite(4'd0, 64'h1000_0001); cfgWrite(4'd4, 64'h0FF0_0000); cfgWrite(4'd8, 64'h2_0000_0000);
    cfgWrite(4'd1, 64'h4000_0003); cfgWrite(4'd5, 64'h0010_0000); cfgWrite(4'd9, 64'h1_0000_0000);
    cfgWrite(4'd2, 64'h1000_0001); cfgWrite(4'd6, 64'h0);         cfgWrite(4'd10, 64'h3_0000_0000);
    // R4 direct hit, R5 priority (window 0 beats window 2)
    xlate(44'h0_1234_5678, 1, 35'h2_0000_0000, 35'h0FFF_FFFF, 0, 0, 0, "R4");
    xlate(44'h0_1001_0000, 1, 35'h2_0000_0000, 35'h0FFF_FFFF, 0, 0, 0, "R5");
    // R7 page-table hit, R8 invalid entry
    xlate(44'h0_4012_3456, 1, 35'h1_2345_6000, 35'h1FFF, 1, 35'h1_0000_0488, 64'h12_3457, "R7");
    xlate(44'h0_4012_3456, 0, 0, 0, 1, 35'h1_0000_0488, 64'hFFFF_0000_0012_3456, "R8");
    // R6 miss
    xlate(44'h0_7000_0000, 0, 0, 0, 0, 0, 0, "R6");
    // R5 disabled window skipped, window 2 now wins
    cfgWrite(4'd0, 64'h1000_0000);
    xlate(44'h0_1001_0000, 1, 35'h3_0000_0000, 35'h000F_FFFF, 0, 0, 0, "R5");
    // R13 busy: second request during fetch is ignored
    @(negedge clk);
    curTag = "R13"; pteAddrExp = 35'h1_0000_0488; pteWord = 64'h12_3457;
    dc = doneCount;
    push(1, 35'h1_2345_6000, 35'h1FFF, 1, "R13");
    xlReq = 1'b1; xlAddr = 44'h0_4012_3456;
    @(negedge clk); xlReq = 1'b0;
    @(negedge clk);
    check(xlBusy, "R13", "busy during fetch", 64'(xlBusy), 64'(1));
    xlReq = 1'b1; xlAddr = 44'h0_1001_0000;
    @(negedge clk); xlReq = 1'b0;
    waitDrain();
    repeat (5) @(negedge clk);
    check(doneCount == dc + 1, "R13", "one pulse only", 64'(doneCount), 64'(dc + 1));
    // R10 window 3 in the 32-bit space
    cfgWrite(4'd3, 64'h8000_0001); cfgWrite(4'd7, 64'h0); cfgWrite(4'd11, 64'h5_0000_0000);
    cfgCheck(4'd3, 64'h8000_0003, "R2");
    xlate(44'h0_8004_5678, 1, 35'h80_0000, 35'h1FFF, 1, 35'h5_0000_0110, 64'h801, "R10");
    cfgWrite(4'd3, 64'h80_8000_0001);
    fc = fetchCount;
    xlate(44'h0_8004_5678, 0, 0, 0, 0, 0, 0, "R10");
    check(fetchCount == fc, "R10", "no fetch", 64'(fetchCount), 64'(fc));
    // R12 dual-address path
    xlate(44'h800_1234_5678, 1, 35'h2000, 35'h1FFF, 1, 35'h5_0004_8D10, 64'h3, "R12");
    xlate(44'h800_1234_5678, 0, 0, 0, 1, 35'h5_0004_8D10, 64'h2, "R12");
    // R11 large window off, then on
    xlate(44'h150_0000_0000, 0, 0, 0, 0, 0, 0, "R11");
    cfgWrite(4'd0, 64'h0000_0001); cfgWrite(4'd4, 64'h0); cfgWrite(4'd8, 64'h6_0000_0000);
    xlate(44'h0_0009_0000, 1, 35'h6_0000_0000, 35'h000F_FFFF, 0, 0, 0, "R9");
    cfgWrite(4'd12, '1);
    cfgCheck(4'd12, 64'h1C_FF0F_C7FF, "R3");
    xlate(44'h150_0000_0000, 1, 35'h0, 35'h7_FFFF_FFFF, 0, 0, 0, "R11");
    // R9 hole inhibits window 0
    fc = fetchCount;
    xlate(44'h0_0009_0000, 0, 0, 0, 0, 0, 0, "R9");
    check(fetchCount == fc, "R9", "no fetch", 64'(fetchCount), 64'(fc));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule